// File: doc/BRIEF.md
# Conditional Data-Processing Execute Unit

This block is the execute stage of a 32-bit integer data path. Each cycle it receives a first operand, a second operand that has already passed through a shifter, and the shifter's carry-out. It also receives a flag telling whether the shift amount was nonzero, a 4-bit operation code, a set-flags bit and a 4-bit condition field. It evaluates the condition against its own stored NZCV flags. It computes one of sixteen arithmetic, logical, test or move results. It then reports whether the destination register may be written and whether the flags change.

The result and both enables come out combinationally in the same cycle as the inputs. The NZCV flags are held in a register inside the block. They are presented on an output and replaced on the next rising clock edge when a flag write is granted. Subtraction follows the inverted-borrow convention: after a subtract, a carry of 1 means that no borrow occurred.

Top module: `dp_exec_unit`

## Requirements
- R1: Opcode values select, in order 0 to 15: AND, EOR, SUB, RSB, ADD, ADC, SBC, RSC, TST, TEQ, CMP, CMN, ORR, MOV, BIC, MVN. The logical results are A&B, A^B, A|B, B (MOV), A&~B (BIC) and ~B (MVN). MOV and MVN do not depend on A.
- R2: ADD gives A+B and ADC gives A+B+C, where C is the stored carry. For ADD and CMN, the new carry is the unsigned carry out of bit 31.
- R3: SUB and CMP give A-B, and RSB gives B-A. SBC gives A-B-(1-C) and RSC gives B-A-(1-C). The new carry is 1 exactly when the unsigned subtraction needs no borrow.
- R4: The flags output is {N,Z,C,V}, with N in bit 3 and V in bit 0. After an arithmetic update, N is result bit 31 and Z is 1 when the result is zero. V is 1 when the signed result overflows.
- R5: After a logical update, N and Z follow the result and V keeps its old value. C takes the shifter carry when the shift-active input is 1; otherwise C keeps its old value.
- R6: When the condition passes, a non-compare operation asserts the flag-write output only when set-flags is 1. Otherwise the flags do not change.
- R7: TST, TEQ, CMP and CMN always assert the flag-write output when their condition passes, whatever the set-flags bit. They never assert the destination write enable.
- R8: Condition codes 0 to 14 are EQ (Z), NE (!Z), CS (C), CC (!C), MI (N), PL (!N), VS (V), VC (!V), HI (C&!Z), LS (!C|Z), GE (N==V), LT (N!=V), GT (!Z&N==V), LE (Z|N!=V) and AL (always). Code 15 never passes.
- R9: When the condition fails, both the destination write enable and the flag-write output are 0, and the flags keep their value.
- R10: A synchronous reset clears the flags to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| sh_carry | input | 1 | Carry-out from the shifter |
| sh_active | input | 1 | 1 when the shift amount was nonzero |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request to update flags |
| cond | input | 4 | Condition field |
| result | output | 32 | Computed result |
| dest_we | output | 1 | Destination register write enable |
| flags_we | output | 1 | Flags are replaced at the next edge |
| flags | output | 4 | Stored NZCV flags |

## Verification
A wrong stored flag bit stays hidden until an instruction reads it. That happens through the condition check, which then flips the two enables in the same cycle, or through ADC, SBC or RSC, whose carry-in shifts the result by one. Wrong carry or overflow logic shows on the flags output one edge after the update. Because a logical update keeps some bits, an error in an earlier arithmetic update can travel through later logical operations before a condition reveals it. The sweep therefore runs every opcode against every condition, with the flags left by the previous step, so errors surface within a few instructions.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_SUB = 4'd2,
        OP_RSB = 4'd3,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_RSC = 4'd7,
        OP_TST = 4'd8,
        OP_TEQ = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_ORR = 4'd12,
        OP_MOV = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } opcode_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,
        CC_NE = 4'd1,
        CC_CS = 4'd2,
        CC_CC = 4'd3,
        CC_MI = 4'd4,
        CC_PL = 4'd5,
        CC_VS = 4'd6,
        CC_VC = 4'd7,
        CC_HI = 4'd8,
        CC_LS = 4'd9,
        CC_GE = 4'd10,
        CC_LT = 4'd11,
        CC_GT = 4'd12,
        CC_LE = 4'd13,
        CC_AL = 4'd14,
        CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Operation class flags produced by the decoder
    typedef struct packed {
        logic is_logic;
        logic is_test;
        logic use_adder;
    } op_class_t;

endpackage

// File: rtl/dpx_cond_check.sv
module dpx_cond_check
    import dpx_pkg::*;
(
    input  nzcv_t      cur,
    input  logic [3:0] cond,
    output logic       pass
);
    logic ge_ok;

    always_comb begin
        ge_ok = (cur.n == cur.v);
        unique case (cond_e'(cond))
            CC_EQ: pass = cur.z;
            CC_NE: pass = !cur.z;
            CC_CS: pass = cur.c;
            CC_CC: pass = !cur.c;
            CC_MI: pass = cur.n;
            CC_PL: pass = !cur.n;
            CC_VS: pass = cur.v;
            CC_VC: pass = !cur.v;
            CC_HI: pass = cur.c && !cur.z;
            CC_LS: pass = !cur.c || cur.z;
            CC_GE: pass = ge_ok;
            CC_LT: pass = !ge_ok;
            CC_GT: pass = !cur.z && ge_ok;
            CC_LE: pass = cur.z || !ge_ok;
            CC_AL: pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/dpx_op_decode.sv
module dpx_op_decode
    import dpx_pkg::*;
(
    input  logic [3:0] opcode,
    output op_class_t  cls
);
    always_comb begin
        cls = '0;
        unique case (opcode_e'(opcode))
            OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: cls.is_logic = 1'b1;
            OP_TST, OP_TEQ: begin
                cls.is_logic = 1'b1;
                cls.is_test  = 1'b1;
            end
            OP_CMP, OP_CMN: begin
                cls.use_adder = 1'b1;
                cls.is_test   = 1'b1;
            end
            default: cls.use_adder = 1'b1;
        endcase
    end
endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
    import dpx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [3:0]    opcode,
    input  logic          carry_in_flag,
    output logic [DW-1:0] res,
    output logic          add_carry,
    output logic          add_ovf
);
    localparam int SW = DW + 1;

    logic [DW-1:0] add_x;
    logic [DW-1:0] add_y;
    logic          add_cin;
    logic [SW-1:0] sum;
    logic [DW-1:0] logic_res;
    logic          pick_adder;

    // Operand steering for the single shared adder
    always_comb begin
        add_x   = op_a;
        add_y   = op_b;
        add_cin = 1'b0;
        pick_adder = 1'b1;
        logic_res  = '0;
        unique case (opcode_e'(opcode))
            OP_SUB, OP_CMP: begin
                add_y   = ~op_b;
                add_cin = 1'b1;
            end
            OP_RSB: begin
                add_x   = op_b;
                add_y   = ~op_a;
                add_cin = 1'b1;
            end
            OP_ADD, OP_CMN: add_cin = 1'b0;
            OP_ADC: add_cin = carry_in_flag;
            OP_SBC: begin
                add_y   = ~op_b;
                add_cin = carry_in_flag;
            end
            OP_RSC: begin
                add_x   = op_b;
                add_y   = ~op_a;
                add_cin = carry_in_flag;
            end
            OP_AND, OP_TST: begin
                pick_adder = 1'b0;
                logic_res  = op_a & op_b;
            end
            OP_EOR, OP_TEQ: begin
                pick_adder = 1'b0;
                logic_res  = op_a ^ op_b;
            end
            OP_ORR: begin
                pick_adder = 1'b0;
                logic_res  = op_a | op_b;
            end
            OP_MOV: begin
                pick_adder = 1'b0;
                logic_res  = op_b;
            end
            OP_BIC: begin
                pick_adder = 1'b0;
                logic_res  = op_a & ~op_b;
            end
            default: begin
                pick_adder = 1'b0;
                logic_res  = ~op_b;
            end
        endcase
    end

    always_comb begin
        sum       = {1'b0, add_x} + {1'b0, add_y} + {{DW{1'b0}}, add_cin};
        add_carry = sum[DW];
        add_ovf   = (add_x[DW-1] == add_y[DW-1]) && (sum[DW-1] != add_x[DW-1]);
        res       = pick_adder ? sum[DW-1:0] : logic_res;
    end
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
    import dpx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          sh_carry,
    input  logic          sh_active,
    input  logic [3:0]    opcode,
    input  logic          set_flags,
    input  logic [3:0]    cond,
    output logic [DW-1:0] result,
    output logic          dest_we,
    output logic          flags_we,
    output logic [3:0]    flags
);
    typedef struct packed {
        nzcv_t flags;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic          cond_pass;
    op_class_t     cls;
    logic [DW-1:0] alu_res;
    logic          alu_carry;
    logic          alu_ovf;
    logic          wr_flags;
    nzcv_t         upd;

    dpx_cond_check u_cond (
        .cur  (state_q.flags),
        .cond (cond),
        .pass (cond_pass)
    );

    dpx_op_decode u_dec (
        .opcode (opcode),
        .cls    (cls)
    );

    dpx_alu #(.DW(DW)) u_alu (
        .op_a          (op_a),
        .op_b          (op_b),
        .opcode        (opcode),
        .carry_in_flag (state_q.flags.c),
        .res           (alu_res),
        .add_carry     (alu_carry),
        .add_ovf       (alu_ovf)
    );

    always_comb begin
        wr_flags = cond_pass && (set_flags || cls.is_test);
        upd.n    = alu_res[DW-1];
        upd.z    = (alu_res == '0);
        if (cls.is_logic) begin
            upd.c = sh_active ? sh_carry : state_q.flags.c;
            upd.v = state_q.flags.v;
        end else begin
            upd.c = alu_carry;
            upd.v = alu_ovf;
        end
        state_d = state_q;
        if (wr_flags) begin
            state_d.flags = upd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result   = alu_res;
    assign dest_we  = cond_pass && !cls.is_test;
    assign flags_we = wr_flags;
    assign flags    = state_q.flags;
endmodule

// File: rtl/dp_exec_unit_chk.sv
module dp_exec_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic          sh_carry,
    input logic          sh_active,
    input logic [3:0]    opcode,
    input logic          set_flags,
    input logic [3:0]    cond,
    input logic [DW-1:0] result,
    input logic          dest_we,
    input logic          flags_we,
    input logic [3:0]    flags
);
    logic is_cmp_grp;
    logic is_logic_grp;

    assign is_cmp_grp   = (opcode[3:2] == 2'b10);
    assign is_logic_grp = (opcode[3:1] == 3'b000) || (opcode[3:1] == 3'b100) ||
                          (opcode[3:2] == 2'b11);

    AST_MOV_IGNORES_A: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd13) |-> (result == op_b));  // R1

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flags_we && !is_logic_grp) |=> (flags[2] == ($past(result) == '0)));  // R4

    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
        (flags_we && is_logic_grp) |=> (flags[0] == $past(flags[0])));  // R5

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flags_we |=> $stable(flags));  // R6

    AST_TEST_NO_DEST: assert property (@(posedge clk) disable iff (rst)
        is_cmp_grp |-> !dest_we);  // R7

    AST_NEVER_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd15) |-> (!dest_we && !flags_we));  // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (flags == 4'b0000));  // R10

endmodule

bind dp_exec_unit dp_exec_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .sh_carry  (sh_carry),
    .sh_active (sh_active),
    .opcode    (opcode),
    .set_flags (set_flags),
    .cond      (cond),
    .result    (result),
    .dest_we   (dest_we),
    .flags_we  (flags_we),
    .flags     (flags)
);

// File: tb/dp_exec_unit_tb.sv
module dp_exec_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 60000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_a, op_b;
    logic        sh_carry, sh_active, set_flags;
    logic [3:0]  opcode, cond;
    logic [31:0] result;
    logic        dest_we, flags_we;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [3:0] m_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_exec_unit u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .sh_carry(sh_carry), .sh_active(sh_active), .opcode(opcode),
        .set_flags(set_flags), .cond(cond), .result(result),
        .dest_we(dest_we), .flags_we(flags_we), .flags(flags)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%0d cond=%0d got=%h exp=%h", tag, opcode, cond, got, exp);
        end
    endtask

    function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] pick_a(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7fff_ffff;
            3: return 32'hffff_ffff;
            4: return 32'h0000_0005;
            5: return 32'h0000_0003;
            6: return 32'h1234_5678;
            default: return 32'h8000_0000;
        endcase
    endfunction

    function automatic logic [31:0] pick_b(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_0001;
            3: return 32'h0000_0001;
            4: return 32'h0000_0005;
            5: return 32'h0000_0007;
            6: return 32'h0f0f_0f0f;
            default: return 32'h8000_0000;
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; op_a = '0; op_b = '0; sh_carry = 0; sh_active = 0;
        opcode = '0; cond = 4'd14; set_flags = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R10", {28'd0, flags}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        m_flags = 4'b0000;

        for (int k = 0; k < 8; k++) begin
            for (int oc = 0; oc < 16; oc++) begin
                for (int cc = 0; cc < 16; cc++) begin
                    for (int m = 0; m < 8; m++) begin
                        logic [31:0] a, b, er;
                        bit ec, ev, pass, is_t, is_l, is_arith, ewe, fwe, mc;
                        longint ua, ub, cin, ures, sa, sb, sres;
                        string rtag;
                        a  = pick_a(k);
                        b  = pick_b(k);
                        if (oc == 13 || oc == 15) a = a ^ 32'h5a5a_a5a5 ^ {29'd0, m[2:0]};
                        @(negedge clk);
                        op_a = a; op_b = b; opcode = 4'(oc); cond = 4'(cc);
                        set_flags = m[0]; sh_active = m[1]; sh_carry = m[2];
                        mc  = m_flags[1];
                        cin = mc ? 0 : 1;
                        ua = longint'(a); ub = longint'(b);
                        sa = longint'($signed(a)); sb = longint'($signed(b));
                        is_t = (oc >= 8 && oc <= 11);
                        is_l = (oc <= 1) || oc == 8 || oc == 9 || oc >= 12;
                        is_arith = !is_l;
                        ec = 0; ev = 0; ures = 0; sres = 0; er = '0;
                        case (oc)
                            0, 8:  er = a & b;
                            1, 9:  er = a ^ b;
                            12:    er = a | b;
                            13:    er = b;
                            14:    er = a & ~b;
                            15:    er = ~b;
                            2, 10: begin ures = ua - ub;       sres = sa - sb; end
                            3:     begin ures = ub - ua;       sres = sb - sa; end
                            4, 11: begin ures = ua + ub;       sres = sa + sb; end
                            5:     begin ures = ua + ub + (mc ? 1 : 0); sres = sa + sb + (mc ? 1 : 0); end
                            6:     begin ures = ua - ub - cin; sres = sa - sb - cin; end
                            default: begin ures = ub - ua - cin; sres = sb - sa - cin; end
                        endcase
                        if (is_arith) begin
                            er = ures[31:0];
                            if (oc == 4 || oc == 5 || oc == 11) ec = (ures > 64'sh0_FFFF_FFFF);
                            else ec = (ures >= 0);
                            ev = (sres > 64'sh7FFF_FFFF) || (sres < -64'sh8000_0000);
                        end
                        pass = cond_ok(4'(cc), m_flags);
                        ewe  = pass && !is_t;
                        fwe  = pass && (m[0] || is_t);
                        rtag = is_l ? "R1" : ((oc == 4 || oc == 5 || oc == 11) ? "R2" : "R3");
                        #(CLK_PERIOD/4);
                        check(rtag, result, er);
                        check(!pass ? "R9" : (is_t ? "R7" : "R8"), {31'd0, dest_we}, {31'd0, ewe});
                        check(!pass ? "R9" : (is_t ? "R7" : "R6"), {31'd0, flags_we}, {31'd0, fwe});
                        if (fwe) begin
                            if (is_l)
                                m_flags = {er[31], er == 0, m[1] ? m[2] : m_flags[1], m_flags[0]};
                            else
                                m_flags = {er[31], er == 0, ec, ev};
                        end
                        @(posedge clk);
                        #1;
                        check(!fwe ? (pass ? "R6" : "R9") : (is_l ? "R5" : "R4"),
                              {28'd0, flags}, {28'd0, m_flags});
                    end
                end
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R10", {28'd0, flags}, 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule